// File: doc/BRIEF.md
# Multiphase Harmonic Lock Detector

This block judges whether a delay line with eight equally spaced taps has settled on the intended delay of one reference period. On each rising edge of the reference clock, external samplers capture the level of every tap. The block receives those eight bits together with a strobe that marks them valid. It matches the pattern against three templates: proper lock at one period, false lock at two periods, and a loop stuck below half a period. A pattern that fits none of them is classed as unknown. The templates rely on the reference and the taps running at about 50% duty cycle.

One classification never moves the reported state on its own. An agreement counter must see the same new class on four consecutive valid samples before the state machine moves. The machine has five states. ST_IDLE is entered on reset and raises no flag. ST_LOCKED, ST_HARMONIC, ST_STUCK and ST_UNKNOWN each raise their own flag. Every transition is a confirmation, taken from any state to the state of the class just confirmed: IDLE→LOCKED/HARMONIC/STUCK/UNKNOWN, LOCKED→HARMONIC/STUCK/UNKNOWN, and so on. Reset returns the machine to ST_IDLE. On entry to ST_HARMONIC or ST_STUCK the block pulses a request so the loop controller can reset its loop filter.

Top module: `phase_lock_classifier`

## Requirements
- R1: Bit i of `ph_bits` is tap i+1 (bit 0 is the first tap). A pattern with bits 0,1,2 high and bits 4,5,6 low, whatever bits 3 and 7 hold, classes as correct lock and, once confirmed, raises `flag_lock`.
- R2: A pattern with bits 0 and 4 high and bits 2 and 6 low, whatever bits 1,3,5,7 hold, classes as harmonic lock and, once confirmed, raises `flag_harm`.
- R3: The pattern with all eight bits high classes as stuck and, once confirmed, raises `flag_stuck`.
- R4: Every pattern that matches none of the three templates classes as unknown and, once confirmed, raises `flag_unknown`.
- R5: The state flags change only on the clock edge that takes the fourth consecutive valid sample of one class different from the current state. A valid sample of another class restarts the count. This includes a sample that matches the current state.
- R6: Cycles with `smp_vld` low neither count toward nor break a run, and they leave every output unchanged.
- R7: At most one state flag is high at any time.
- R8: `loop_rst_req` is high for exactly one cycle, on the edge where ST_HARMONIC or ST_STUCK is entered. It stays low on entry to ST_LOCKED or ST_UNKNOWN.
- R9: `lock_confirmed` is high only while `flag_lock` is high and the most recent valid sample classed as correct lock. A single disagreeing sample clears it at once while `flag_lock` holds, and the next correct sample sets it again.
- R10: A synchronous active-high `rst` clears all flags, the request pulse and the agreement count, and returns the machine to ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Marks `ph_bits` as a fresh sample |
| ph_bits | input | 8 | Sampled tap levels, bit 0 = first tap |
| flag_lock | output | 1 | Correct lock state confirmed |
| flag_harm | output | 1 | Harmonic lock state confirmed |
| flag_stuck | output | 1 | Stuck-short state confirmed |
| flag_unknown | output | 1 | Unclassifiable state confirmed |
| lock_confirmed | output | 1 | Locked, and the latest sample agrees |
| loop_rst_req | output | 1 | One-cycle loop reset request |

## Verification
The bench sweeps all 256 sample patterns through four valid samples each. It checks that nothing moves after three samples and that the right flag and pulse appear after the fourth. A template with a wrongly placed don't-care bit, or a bit-order swap, would therefore misclass some patterns. Directed runs cover the cases an agreement counter most easily gets wrong. One is a sample that matches the current state inside a run, which a sloppy counter would skip instead of restarting. Others are a run broken by a third class, and gaps in the strobe that a wrong design would count or treat as a break. The runs also check that the confirmation flag drops on one disagreeing sample while the state holds, and that the request fires on a harmonic or stuck entry but not on an unknown one.

// File: rtl/hld_pkg.sv
package hld_pkg;

    // Class of one sampled tap pattern
    typedef enum logic [1:0] {
        CLS_LOCK  = 2'd0,
        CLS_HARM  = 2'd1,
        CLS_STUCK = 2'd2,
        CLS_UNK   = 2'd3
    } cls_t;

    // Qualified state of the detector
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LOCKED   = 3'd1,
        ST_HARMONIC = 3'd2,
        ST_STUCK    = 3'd3,
        ST_UNKNOWN  = 3'd4
    } st_t;

endpackage

// File: rtl/hld_classify.sv
module hld_classify
    import hld_pkg::*;
#(
    parameter int NUM_PH = 8
) (
    input  logic [NUM_PH-1:0] bits,
    output cls_t              cls
);
    localparam int HALF = NUM_PH / 2;
    localparam int QTR  = NUM_PH / 4;

    // Template masks: correct lock fills the first half minus its last tap.
    // Harmonic lock repeats that shape with half the period.
    logic [NUM_PH-1:0] lk_one, lk_zero, hm_one, hm_zero;

    for (genvar i = 0; i < NUM_PH; i++) begin : g_mask
        assign lk_one[i]  = (i < HALF - 1);
        assign lk_zero[i] = (i >= HALF) && (i < NUM_PH - 1);
        assign hm_one[i]  = ((i % HALF) < QTR - 1) || ((i % HALF) == 0);
        assign hm_zero[i] = ((i % HALF) >= QTR) && ((i % HALF) < HALF - 1);
    end

    logic is_lock, is_harm, is_stuck;

    assign is_lock  = ((bits & lk_one) == lk_one) && ((bits & lk_zero) == '0);
    assign is_harm  = ((bits & hm_one) == hm_one) && ((bits & hm_zero) == '0);
    assign is_stuck = &bits;

    always_comb begin
        if (is_lock)
            cls = CLS_LOCK;
        else if (is_harm)
            cls = CLS_HARM;
        else if (is_stuck)
            cls = CLS_STUCK;
        else
            cls = CLS_UNK;
    end

endmodule

// File: rtl/hld_agree.sv
module hld_agree
    import hld_pkg::*;
#(
    parameter int QUAL_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_vld,
    input  cls_t cls,
    input  cls_t cur_cls,
    input  logic cur_valid,
    output logic confirm
);
    localparam int CW = $clog2(QUAL_LEN + 1);

    cls_t          cand, cand_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        confirm = 1'b0;
        cand_nx = cand;
        cnt_nx  = cnt;
        if (smp_vld) begin
            if (cur_valid && cls == cur_cls) begin
                cnt_nx = '0;
            end else if (cnt != '0 && cls == cand) begin
                if (cnt == CW'(QUAL_LEN - 1)) begin
                    confirm = 1'b1;
                    cnt_nx  = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end else begin
                cand_nx = cls;
                if (QUAL_LEN == 1) begin
                    confirm = 1'b1;
                    cnt_nx  = '0;
                end else begin
                    cnt_nx = CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand <= CLS_UNK;
            cnt  <= '0;
        end else begin
            cand <= cand_nx;
            cnt  <= cnt_nx;
        end
    end

endmodule

// File: rtl/phase_lock_classifier.sv
module phase_lock_classifier
    import hld_pkg::*;
#(
    parameter int NUM_PH   = 8,
    parameter int QUAL_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [NUM_PH-1:0] ph_bits,
    output logic              flag_lock,
    output logic              flag_harm,
    output logic              flag_stuck,
    output logic              flag_unknown,
    output logic              lock_confirmed,
    output logic              loop_rst_req
);
    cls_t cls;
    cls_t cur_cls;
    logic cur_valid;
    logic confirm;
    st_t  state, state_nx;

    hld_classify #(.NUM_PH(NUM_PH)) u_cls (
        .bits (ph_bits),
        .cls  (cls)
    );

    hld_agree #(.QUAL_LEN(QUAL_LEN)) u_agree (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .cls       (cls),
        .cur_cls   (cur_cls),
        .cur_valid (cur_valid),
        .confirm   (confirm)
    );

    // Class that the present state stands for
    always_comb begin
        cur_valid = 1'b1;
        cur_cls   = CLS_UNK;
        unique case (state)
            ST_IDLE:     cur_valid = 1'b0;
            ST_LOCKED:   cur_cls   = CLS_LOCK;
            ST_HARMONIC: cur_cls   = CLS_HARM;
            ST_STUCK:    cur_cls   = CLS_STUCK;
            ST_UNKNOWN:  cur_cls   = CLS_UNK;
            default:     cur_valid = 1'b0;
        endcase
    end

    // Transitions happen only on a confirmed class
    always_comb begin
        state_nx = state;
        if (confirm) begin
            unique case (cls)
                CLS_LOCK:  state_nx = ST_LOCKED;
                CLS_HARM:  state_nx = ST_HARMONIC;
                CLS_STUCK: state_nx = ST_STUCK;
                CLS_UNK:   state_nx = ST_UNKNOWN;
                default:   state_nx = ST_UNKNOWN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_lock      <= 1'b0;
            flag_harm      <= 1'b0;
            flag_stuck     <= 1'b0;
            flag_unknown   <= 1'b0;
            lock_confirmed <= 1'b0;
            loop_rst_req   <= 1'b0;
        end else begin
            flag_lock    <= (state_nx == ST_LOCKED);
            flag_harm    <= (state_nx == ST_HARMONIC);
            flag_stuck   <= (state_nx == ST_STUCK);
            flag_unknown <= (state_nx == ST_UNKNOWN);
            loop_rst_req <= confirm && (cls == CLS_HARM || cls == CLS_STUCK);
            if (state_nx != ST_LOCKED)
                lock_confirmed <= 1'b0;
            else if (smp_vld)
                lock_confirmed <= (cls == CLS_LOCK);
        end
    end

endmodule

// File: rtl/hld_checker.sv
module hld_checker (
    input logic clk,
    input logic rst,
    input logic smp_vld,
    input logic flag_lock,
    input logic flag_harm,
    input logic flag_stuck,
    input logic flag_unknown,
    input logic lock_confirmed,
    input logic loop_rst_req
);
    logic [3:0] flags;
    assign flags = {flag_lock, flag_harm, flag_stuck, flag_unknown};

    assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags));

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == 4'b0 && !lock_confirmed && !loop_rst_req));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        loop_rst_req |=> !loop_rst_req);

    assert_pulse_entry_R8: assert property (@(posedge clk) disable iff (rst)
        loop_rst_req |-> (flag_harm || flag_stuck));

    assert_confirm_in_lock_R9: assert property (@(posedge clk) disable iff (rst)
        lock_confirmed |-> flag_lock);

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(flags) && $stable(lock_confirmed) && !loop_rst_req));

endmodule

bind phase_lock_classifier hld_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .smp_vld        (smp_vld),
    .flag_lock      (flag_lock),
    .flag_harm      (flag_harm),
    .flag_stuck     (flag_stuck),
    .flag_unknown   (flag_unknown),
    .lock_confirmed (lock_confirmed),
    .loop_rst_req   (loop_rst_req)
);

// File: tb/phase_lock_classifier_test.sv
module phase_lock_classifier_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_vld = 1'b0;
    logic [7:0] ph_bits = 8'h00;
    logic       flag_lock, flag_harm, flag_stuck, flag_unknown;
    logic       lock_confirmed, loop_rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [3:0] F_NONE = 4'b0000;
    localparam logic [3:0] F_LOCK = 4'b1000;
    localparam logic [3:0] F_HARM = 4'b0100;
    localparam logic [3:0] F_STK  = 4'b0010;
    localparam logic [3:0] F_UNK  = 4'b0001;

    localparam logic [7:0] P_LOCK = 8'b0000_0111;
    localparam logic [7:0] P_HARM = 8'b0001_0001;
    localparam logic [7:0] P_STK  = 8'hFF;
    localparam logic [7:0] P_UNK  = 8'h00;

    always #4 clk = ~clk;

    phase_lock_classifier uut (
        .clk            (clk),
        .rst            (rst),
        .smp_vld        (smp_vld),
        .ph_bits        (ph_bits),
        .flag_lock      (flag_lock),
        .flag_harm      (flag_harm),
        .flag_stuck     (flag_stuck),
        .flag_unknown   (flag_unknown),
        .lock_confirmed (lock_confirmed),
        .loop_rst_req   (loop_rst_req)
    );

    // Expected flag word from the templates of R1..R4
    function automatic logic [3:0] exp_flags(logic [7:0] b);
        if (b[0] && b[1] && b[2] && !b[4] && !b[5] && !b[6]) return F_LOCK;
        if (b[0] && !b[2] && b[4] && !b[6])                 return F_HARM;
        if (b == 8'hFF)                                     return F_STK;
        return F_UNK;
    endfunction

    function automatic string req_of(logic [3:0] f);
        case (f)
            F_LOCK:  return "R1";
            F_HARM:  return "R2";
            F_STK:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk_flags(string req, logic [3:0] exp);
        logic [3:0] act;
        act = {flag_lock, flag_harm, flag_stuck, flag_unknown};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s flags actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Drive one valid sample at a falling edge
    task automatic send(logic [7:0] b);
        @(negedge clk);
        smp_vld = 1'b1;
        ph_bits = b;
    endtask

    task automatic gap();
        @(negedge clk);
        smp_vld = 1'b0;
        ph_bits = 8'hA5;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_n(logic [7:0] b, int n);
        for (int k = 0; k < n; k++) send(b);
    endtask

    initial begin
        do_reset();
        chk_flags("R10", F_NONE);
        chk_bit("R10", "lock_confirmed", lock_confirmed, 1'b0);
        chk_bit("R10", "loop_rst_req", loop_rst_req, 1'b0);

        // Exhaustive sweep: every pattern, four samples each
        for (int p = 0; p < 256; p++) begin
            logic [3:0] ef;
            ef = exp_flags(8'(p));
            do_reset();
            send_n(8'(p), 3);
            @(negedge clk);
            chk_flags("R5", F_NONE);
            smp_vld = 1'b1;
            ph_bits = 8'(p);
            gap();
            chk_flags(req_of(ef), ef);
            chk_bit("R8", "loop_rst_req", loop_rst_req, (ef == F_HARM || ef == F_STK));
            chk_bit("R9", "lock_confirmed", lock_confirmed, (ef == F_LOCK));
            gap();
            chk_bit("R8", "loop_rst_req second cycle", loop_rst_req, 1'b0);
            chk_flags("R6", ef);
        end

        // R6: gaps between samples neither count nor break the run
        do_reset();
        send(P_LOCK); gap(); send(P_LOCK); gap(); gap(); send(P_LOCK); gap();
        chk_flags("R6", F_NONE);
        send(P_LOCK); gap();
        chk_flags("R6", F_LOCK);

        // R5/R9: a sample matching the current state restarts the run
        send_n(P_HARM, 3); gap();
        chk_flags("R5", F_LOCK);
        chk_bit("R9", "lock_confirmed after disagreement", lock_confirmed, 1'b0);
        send(P_LOCK); gap();
        chk_bit("R9", "lock_confirmed after agreement", lock_confirmed, 1'b1);
        send_n(P_HARM, 3); gap();
        chk_flags("R5", F_LOCK);
        send(P_HARM); gap();
        chk_flags("R2", F_HARM);
        chk_bit("R8", "loop_rst_req on harmonic entry", loop_rst_req, 1'b1);
        chk_bit("R9", "lock_confirmed outside lock", lock_confirmed, 1'b0);

        // R8: unknown entry gives no request
        send_n(P_UNK, 4); gap();
        chk_flags("R4", F_UNK);
        chk_bit("R8", "loop_rst_req on unknown entry", loop_rst_req, 1'b0);

        // R5: a third class breaks the run
        send_n(P_STK, 2); send(P_HARM); send_n(P_STK, 3); gap();
        chk_flags("R5", F_UNK);
        send(P_STK); gap();
        chk_flags("R3", F_STK);
        chk_bit("R8", "loop_rst_req on stuck entry", loop_rst_req, 1'b1);

        // R10: reset from a confirmed state, partial run discarded
        send_n(P_LOCK, 3);
        do_reset();
        chk_flags("R10", F_NONE);
        send(P_LOCK); gap();
        chk_flags("R10", F_NONE);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule